// File: doc/BRIEF.md
# Stack Push and Call Unit

This unit carries out the two stack-writing operations of a 16-bit register-based processor. A plain push stores an operand word on the stack. A subroutine call stores the return address on the stack and then redirects the program counter to the target. The decoder and the operand fetch logic give the unit a one-cycle start strobe, an operation select, the resolved operand word and the address of the following instruction. That address is the program counter after it has already stepped past every word of the instruction, so a call with an immediate target at address A returns to A+4.

The unit reads the current stack pointer, which is register 1 of the register file. It writes back the stack pointer lowered by two and, for a call, writes register 0, the program counter. The word goes to a byte-wide data-memory write port as two single-byte writes on consecutive cycles, low byte first. The low byte lands at the new stack pointer and the high byte one address above it. A one-cycle done pulse follows the last byte write.

Top module: `stk_push_call`

## Requirements
- R1: A synchronous reset (`rst` high) puts the unit in idle. In the cycle after any reset cycle, `mem_we`, `done`, `sp_wr_en` and `pc_wr_en` are all 0.
- R2: In the first cycle after an accepted start, `sp_wr_en` is 1 for exactly that one cycle, and `sp_wr_data` is the start-cycle `sp_rd` minus 2.
- R3: The word is written over two consecutive cycles, starting the cycle after start. The first write goes to address `sp_rd`−2 with the low byte (bits 7:0). The second goes to address `sp_rd`−1 with the high byte (bits 15:8).
- R4: When `op_call` is 0 (push), the stored word is `operand`.
- R5: When `op_call` is 1 (call), the stored word is `next_pc`, the return address that lies past the whole instruction.
- R6: For a call, `pc_wr_en` is 1 with `pc_wr_data` equal to `operand`, only in the done cycle. For a push, `pc_wr_en` never rises.
- R7: `done` is high for exactly one cycle. That cycle comes right after the second byte write, and `done` is never high in the same cycle as `mem_we`.
- R8: A `start` that is high while an operation is in progress is ignored. The bytes written and the done timing follow the operation that was accepted.
- R9: Stack-pointer arithmetic wraps modulo 2^16. A stack pointer of 0x0000 writes bytes to 0xFFFE and 0xFFFF, and the new stack pointer is 0xFFFE.
- R10: `sp_rd`, `operand`, `next_pc` and `op_call` are sampled only in the cycle where start is accepted. Later changes to them do not affect the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_call | input | 1 | 0 = push operand, 1 = call operand |
| operand | input | 16 | Word to push, or call target |
| next_pc | input | 16 | Incremented program counter (return address) |
| sp_rd | input | 16 | Current stack-pointer register value |
| sp_wr_en | output | 1 | Stack-pointer register write enable |
| sp_wr_data | output | 16 | New stack-pointer value |
| pc_wr_en | output | 1 | Program-counter register write enable |
| pc_wr_data | output | 16 | New program-counter value |
| mem_we | output | 1 | Data-memory byte write enable |
| mem_addr | output | 16 | Data-memory byte address |
| mem_wdata | output | 8 | Data-memory byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
Faults in the latched frame appear within two cycles of start. A bad stack-pointer decrement shows up as a wrong `mem_addr` and `sp_wr_data` in the first write cycle. A wrong word select, push against call, shows up as a wrong `mem_wdata` in the first or second write cycle. A sequencer that skips or repeats a state shows up within three cycles: either the address step between the two writes is missing, or `done` rises early, late, twice, or overlaps a write. A stale call flag shows up only in the done cycle, as a program-counter write on a push or a missing one on a call.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    STK_IDLE  = 2'd0,
    STK_WRITE = 2'd1,
    STK_DONE  = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int NBYTES = 2,
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              capture,
  output logic              write_act,
  output logic              first_byte,
  output logic              last_byte,
  output logic              fin,
  output logic [BIDX_W-1:0] byte_idx
);
  import stk_pkg::*;

  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(NBYTES - 1);

  stk_state_e st_q;
  logic [BIDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= STK_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        STK_IDLE: begin
          idx_q <= '0;
          if (start) st_q <= STK_WRITE;
        end
        STK_WRITE: begin
          if (idx_q == LAST_IDX) st_q <= STK_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        STK_DONE: st_q <= STK_IDLE;
        default:  st_q <= STK_IDLE;
      endcase
    end
  end

  always_comb begin
    capture    = (st_q == STK_IDLE) && start;
    write_act  = (st_q == STK_WRITE);
    first_byte = write_act && (idx_q == '0);
    last_byte  = write_act && (idx_q == LAST_IDX);
    fin        = (st_q == STK_DONE);
    byte_idx   = idx_q;
  end
endmodule

// File: rtl/stk_frame.sv
module stk_frame #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              op_call,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] next_pc,
  input  logic [DATA_W-1:0] sp_rd,
  output logic [DATA_W-1:0] sp_new,
  output logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] target,
  output logic              is_call
);
  // Stack grows downward by one whole word, wrapping modulo 2^DATA_W.
  function automatic logic [DATA_W-1:0] f_sp_dec(input logic [DATA_W-1:0] sp);
    return sp - DATA_W'(NBYTES);
  endfunction

  // Word that lands on the stack: the return address for a call.
  function automatic logic [DATA_W-1:0] f_stack_word(input logic is_c,
                                                     input logic [DATA_W-1:0] opnd,
                                                     input logic [DATA_W-1:0] ret);
    return is_c ? ret : opnd;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_new  <= '0;
      word    <= '0;
      target  <= '0;
      is_call <= 1'b0;
    end else if (capture) begin
      sp_new  <= f_sp_dec(sp_rd);
      word    <= f_stack_word(op_call, operand, next_pc);
      target  <= operand;
      is_call <= op_call;
    end
  end
endmodule

// File: rtl/stk_byte_sel.sv
module stk_byte_sel #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] word,
  input  logic [BIDX_W-1:0] idx,
  output logic [DATA_W-1:0] addr,
  output logic [BYTE_W-1:0] bdata
);
  // Little-endian: byte k of the word lives at base + k.
  function automatic logic [DATA_W-1:0] f_byte_addr(input logic [DATA_W-1:0] b,
                                                    input logic [BIDX_W-1:0] k);
    return b + DATA_W'(k);
  endfunction

  logic [BYTE_W-1:0] lanes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = word[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    addr  = f_byte_addr(base, idx);
    bdata = lanes[0];
    for (int k = 1; k < NBYTES; k++) begin
      if (idx == BIDX_W'(k)) bdata = lanes[k];
    end
  end
endmodule

// File: rtl/stk_push_call.sv
module stk_push_call #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_call,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] next_pc,
  input  logic [DATA_W-1:0] sp_rd,
  output logic              sp_wr_en,
  output logic [DATA_W-1:0] sp_wr_data,
  output logic              pc_wr_en,
  output logic [DATA_W-1:0] pc_wr_data,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              done
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  // Named internal events, visible to the bound checker.
  logic              capture;
  logic              write_act;
  logic              first_byte;
  logic              last_byte;
  logic              fin;
  logic [BIDX_W-1:0] byte_idx;
  logic [DATA_W-1:0] sp_new;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] target;
  logic              is_call;

  stk_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .capture(capture), .write_act(write_act),
    .first_byte(first_byte), .last_byte(last_byte),
    .fin(fin), .byte_idx(byte_idx)
  );

  stk_frame #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst(rst), .capture(capture),
    .op_call(op_call), .operand(operand), .next_pc(next_pc), .sp_rd(sp_rd),
    .sp_new(sp_new), .word(word), .target(target), .is_call(is_call)
  );

  stk_byte_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bsel (
    .base(sp_new), .word(word), .idx(byte_idx),
    .addr(mem_addr), .bdata(mem_wdata)
  );

  always_comb begin
    mem_we     = write_act;
    sp_wr_en   = first_byte;
    sp_wr_data = sp_new;
    pc_wr_en   = fin && is_call;
    pc_wr_data = target;
    done       = fin;
  end
endmodule

// File: rtl/stk_push_call_chk.sv
module stk_push_call_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic              done,
  input logic              sp_wr_en,
  input logic [DATA_W-1:0] sp_wr_data,
  input logic              pc_wr_en,
  input logic              last_byte
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mem_we && !done && !sp_wr_en && !pc_wr_en));

  assert_sp_matches_first_addr_R2: assert property (@(posedge clk) disable iff (rst)
    sp_wr_en |-> (mem_we && mem_addr == sp_wr_data));

  assert_addr_steps_up_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !last_byte) |=> (mem_we && mem_addr == $past(mem_addr) + DATA_W'(1)));

  assert_pc_only_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    pc_wr_en |-> done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && last_byte) |=> done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, mem_we}));
endmodule

bind stk_push_call stk_push_call_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr), .done(done),
  .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .pc_wr_en(pc_wr_en),
  .last_byte(last_byte)
);

// File: tb/stk_push_call_tb.sv
module stk_push_call_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_call = 1'b0;
  logic [15:0] operand = '0;
  logic [15:0] next_pc = '0;
  logic [15:0] sp_rd = '0;
  logic        sp_wr_en, pc_wr_en, mem_we, done;
  logic [15:0] sp_wr_data, pc_wr_data, mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] sp_seen = '0;
  logic [15:0] pc_seen = '0;

  always #4 clk = ~clk;  // 125 MHz

  stk_push_call u_dut (
    .clk(clk), .rst(rst), .start(start), .op_call(op_call),
    .operand(operand), .next_pc(next_pc), .sp_rd(sp_rd),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  // Register-file model: records what the unit writes.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sp_wr_en) sp_seen <= sp_wr_data;
    if (pc_wr_en) pc_seen <= pc_wr_data;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (act cycles=%0d, exp < 20000)", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Issue one operation, check every cycle until the unit is idle again.
  task automatic run_op(input logic c, input logic [15:0] opnd, input logic [15:0] npc, input logic [15:0] sp0);
    logic [15:0] w;
    logic [15:0] nsp;
    w   = c ? npc : opnd;
    nsp = sp0 - 16'd2;
    @(negedge clk);
    op_call = c; operand = opnd; next_pc = npc; sp_rd = sp0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: disturb the sampled inputs once the start has been taken
    operand = ~opnd; next_pc = ~npc; sp_rd = ~sp0; op_call = ~c;
    chk(mem_we && mem_addr == nsp, "R3 low addr", {mem_we, mem_addr}, {1'b1, nsp});
    chk(mem_wdata == w[7:0], c ? "R5 low byte" : "R4 low byte", mem_wdata, w[7:0]);
    chk(sp_wr_en && sp_wr_data == nsp, "R2 sp write", {sp_wr_en, sp_wr_data}, {1'b1, nsp});
    chk(!done && !pc_wr_en, "R7 no early done", {done, pc_wr_en}, 0);
    @(negedge clk);
    chk(mem_we && mem_addr == nsp + 16'd1, "R3 high addr R10", {mem_we, mem_addr}, {1'b1, nsp + 16'd1});
    chk(mem_wdata == w[15:8], c ? "R5 high byte" : "R4 high byte", mem_wdata, w[15:8]);
    chk(!sp_wr_en, "R2 single sp write", sp_wr_en, 0);
    @(negedge clk);
    chk(done && !mem_we, "R7 done after last write", {done, mem_we}, 2'b10);
    chk(pc_wr_en == c, "R6 pc write only on call", pc_wr_en, c);
    if (c) chk(pc_wr_data == opnd, "R6 call target", pc_wr_data, opnd);
    @(negedge clk);
    chk(!done && !mem_we, "R7 done is one cycle", {done, mem_we}, 0);
    chk(sp_seen == nsp, "R2 sp register", sp_seen, nsp);
  endtask

  // {op_call, operand, next_pc, sp}
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 16'hdead, 16'hc0e2, 16'h1234},
    {1'b0, 16'hdead, 16'h0000, 16'h1234},
    {1'b0, 16'h000a, 16'h4476, 16'h43f0},
    {1'b1, 16'h4558, 16'h445c, 16'h4400},
    {1'b0, 16'h0002, 16'h4550, 16'h0000},  // R9 wrap
    {1'b1, 16'h1234, 16'hc0e2, 16'h0001}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_we && !done && !sp_wr_en && !pc_wr_en, "R1 reset outputs",
        {mem_we, done, sp_wr_en, pc_wr_en}, 0);
    rst = 1'b0;

    foreach (VEC[i]) run_op(VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);

    // R9: wrap explicitly
    run_op(1'b0, 16'hbeef, 16'h0000, 16'h0000);
    chk(sp_seen == 16'hfffe, "R9 wrapped sp", sp_seen, 16'hfffe);
    // R6: call leaves pc at target
    run_op(1'b1, 16'hdead, 16'hc0e2, 16'h1234);
    chk(pc_seen == 16'hdead, "R6 pc register", pc_seen, 16'hdead);

    // R8: start held high during the write cycles is ignored
    @(negedge clk);
    op_call = 1'b0; operand = 16'h5a3c; sp_rd = 16'h2000; start = 1'b1;
    @(negedge clk);
    operand = 16'h1111; sp_rd = 16'h3000;  // start still high
    chk(mem_addr == 16'h1ffe && mem_wdata == 8'h3c, "R8 first byte", {mem_addr, mem_wdata}, {16'h1ffe, 8'h3c});
    @(negedge clk);
    chk(mem_addr == 16'h1fff && mem_wdata == 8'h5a, "R8 second byte", {mem_addr, mem_wdata}, {16'h1fff, 8'h5a});
    start = 1'b0;
    @(negedge clk);
    chk(done && !mem_we, "R8 done on time", {done, mem_we}, 2'b10);
    @(negedge clk);
    chk(!mem_we && !done, "R8 no second operation", {mem_we, done}, 0);

    // R1: reset in mid-operation aborts with no further writes or done
    @(negedge clk);
    op_call = 1'b1; operand = 16'h7777; sp_rd = 16'h0800; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!mem_we && !done && !pc_wr_en, "R1 reset mid-op", {mem_we, done, pc_wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_we && !done && !pc_wr_en, "R1 stays idle", {mem_we, done, pc_wr_en}, 0);

    summary();
  end
endmodule